// File: doc/BRIEF.md
# Systolic Pipelined FIR Filter

This block is a fully parallel finite impulse response filter laid out as a systolic array. Every tap owns a multiplier and a register in a running-sum chain. Each incoming sample moves through a register cascade with two stages between neighbouring taps. As a result, no input net reaches more than one tap, and the design accepts one sample and delivers one filtered result on every clock.

The coefficients are fixed when the block is built, through a parameter array. The stream is continuous and has no stall. A cycle with the input valid low feeds a zero sample into the filter. That cycle's result emerges with the output valid low. The internal sum is wide enough that it can never overflow. The output width is a parameter: when it is narrower than the internal sum, the result is clamped to the output range.

Top module: `fir_systolic`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and result_o is 0, whatever the inputs do.
- R2: For a sample accepted at edge n, the result equals the sum over k of COEFS[k] times the sample accepted at edge n-k. Samples accepted before reset was released count as zero.
- R3: The result for the sample taken at clock edge n is visible on result_o after edge n+N+2.
- R4: With valid_i held high, valid_o is high on every cycle once the pipeline has filled, so one result is delivered per clock.
- R5: A cycle with valid_i low enters the filter as a zero sample, whatever sample_i holds. The result for that cycle comes out with valid_o low.
- R6: valid_o stays low for the first N+2 edges after reset release. After that, valid_o is high only for results whose sample had valid_i high.
- R7: When OW is less than the internal sum width, a sum above 2^(OW-1)-1 outputs 2^(OW-1)-1, and a sum below -2^(OW-1) outputs -2^(OW-1).
- R8: When OW is at least SW+CW+ceil(log2 N), the result is exact for all inputs, including the most negative sample against the most negative coefficient.
- R9: A single unit impulse produces COEFS[0], COEFS[1], ..., COEFS[N-1] on consecutive valid outputs, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample qualifier; low injects a zero sample |
| sample_i | input | SW | Signed input sample |
| valid_o | output | 1 | Result qualifier |
| result_o | output | OW | Signed filtered result |

## Verification
The bench targets three failure modes:
- **Tap and delay misalignment.** An impulse is driven through the filter. If the sample cascade had one stage per tap instead of two, the coefficients would come out spread apart or out of order. A one-off latency error would shift every result by one slot.
- **Gap handling.** The bench drives a full-scale value on sample_i while valid_i is low. A design that let that value into the cascade would corrupt later results. A design that lost track of the gap in its valid pipeline would flag the wrong outputs.
- **Arithmetic extremes.** The most negative sample is held against a most-negative coefficient. A narrow product or sum would wrap sign there. A second instance with a narrow output confirms clamping at both rails.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // full-precision sum width: product plus growth over n terms
  function automatic int acc_width(input int sw, input int cw, input int n);
    return sw + cw + $clog2(n);
  endfunction

  // edges from sample capture to visible result
  function automatic int pipe_latency(input int n);
    return n + 2;
  endfunction

endpackage

// File: rtl/fir_delay2.sv
module fir_delay2 #(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] d_i,
  output logic signed [W-1:0] q_o
);
  logic signed [W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
      q_o   <= '0;
    end else begin
      stg_q <= d_i;
      q_o   <= stg_q;
    end
  end
endmodule

// File: rtl/fir_mac_cell.sv
module fir_mac_cell #(
  parameter int                     SW   = 16,
  parameter int                     CW   = 16,
  parameter int                     AW   = 35,
  parameter logic signed [CW-1:0]   COEF = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [SW-1:0] x_i,
  input  logic signed [AW-1:0] sum_i,
  output logic signed [AW-1:0] sum_o
);
  localparam int PW = SW + CW;

  logic signed [PW-1:0] prod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      sum_o  <= '0;
    end else begin
      prod_q <= PW'(x_i) * PW'(COEF);
      sum_o  <= sum_i + AW'(prod_q);
    end
  end
endmodule

// File: rtl/fir_valid_pipe.sv
module fir_valid_pipe #(
  parameter int DEPTH = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic v_i,
  output logic v_o
);
  logic [DEPTH-1:0] sr_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= v_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[DEPTH-2:0], v_i};
      end
    end
  endgenerate

  assign v_o = sr_q[DEPTH-1];
endmodule

// File: rtl/fir_out_sat.sv
module fir_out_sat #(
  parameter int AW = 35,
  parameter int OW = 35
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [AW-1:0] acc_i,
  output logic signed [OW-1:0] res_o
);
  generate
    if (OW >= AW) begin : g_wide
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_o <= '0;
        else         res_o <= OW'(acc_i);
      end
    end else begin : g_clamp
      localparam logic signed [AW-1:0] HI = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
      localparam logic signed [AW-1:0] LO = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         res_o <= '0;
        else if (acc_i > HI) res_o <= HI[OW-1:0];
        else if (acc_i < LO) res_o <= LO[OW-1:0];
        else                 res_o <= acc_i[OW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/fir_systolic.sv
module fir_systolic #(
  parameter int                   N     = 8,
  parameter int                   SW    = 16,
  parameter int                   CW    = 16,
  parameter logic signed [CW-1:0] COEFS [N] = '{16'sh8000, 16'sd1200, -16'sd3, 16'sd517,
                                                16'sh7FFF, -16'sd900, 16'sd64, 16'sd5},
  parameter int                   OW    = fir_pkg::acc_width(SW, CW, N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [SW-1:0] sample_i,
  output logic                 valid_o,
  output logic signed [OW-1:0] result_o
);
  localparam int AW  = fir_pkg::acc_width(SW, CW, N);
  localparam int LAT = fir_pkg::pipe_latency(N);

  logic signed [SW-1:0] x_q;
  logic signed [SW-1:0] xs   [N];
  logic signed [AW-1:0] sums [N];

  // gaps enter as zero samples; only this register sees sample_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      x_q <= '0;
    else if (valid_i) x_q <= sample_i;
    else              x_q <= '0;
  end

  assign xs[0] = x_q;

  generate
    for (genvar k = 0; k < N; k++) begin : g_tap
      logic signed [AW-1:0] sum_in;

      if (k == 0) begin : g_head
        assign sum_in = '0;
      end else begin : g_link
        assign sum_in = sums[k-1];
        fir_delay2 #(.W(SW)) u_dly (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .d_i    (xs[k-1]),
          .q_o    (xs[k])
        );
      end

      fir_mac_cell #(
        .SW   (SW),
        .CW   (CW),
        .AW   (AW),
        .COEF (COEFS[k])
      ) u_mac (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .x_i    (xs[k]),
        .sum_i  (sum_in),
        .sum_o  (sums[k])
      );
    end
  endgenerate

  fir_out_sat #(.AW(AW), .OW(OW)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (sums[N-1]),
    .res_o  (result_o)
  );

  fir_valid_pipe #(.DEPTH(LAT + 1)) u_vld (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (valid_i),
    .v_o    (valid_o)
  );
endmodule

// File: rtl/fir_systolic_chk.sv
module fir_systolic_chk #(
  parameter int LAT = 10,
  parameter int AW  = 35,
  parameter int OW  = 35
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_o,
  input logic signed [AW-1:0] acc_i,
  input logic signed [OW-1:0] result_o
);
  localparam int CNTW = $clog2(LAT + 2) + 1;

  logic [CNTW-1:0] since_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        since_rst_q <= '0;
    else if (since_rst_q <= CNTW'(LAT)) since_rst_q <= since_rst_q + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && result_o == '0));

  // R6
  early_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q <= CNTW'(LAT)) |-> !valid_o);

  // R2
  known_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({valid_o, result_o}));

  generate
    if (OW >= AW) begin : g_wide
      // R8
      exact_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (result_o == OW'($past(acc_i))));
    end else begin : g_clamp
      localparam logic signed [AW-1:0] HI = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
      localparam logic signed [AW-1:0] LO = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};
      // R7
      clamp_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_i > HI) |=> (result_o == HI[OW-1:0]));
      // R7
      clamp_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_i < LO) |=> (result_o == LO[OW-1:0]));
      // R7
      in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_i <= HI && acc_i >= LO) |=> (AW'(result_o) == $past(acc_i)));
    end
  endgenerate
endmodule

bind fir_systolic fir_systolic_chk #(.LAT(LAT), .AW(AW), .OW(OW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_o  (valid_o),
  .acc_i    (sums[N-1]),
  .result_o (result_o)
);

// File: tb/fir_systolic_tb_top.sv
module fir_systolic_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int SW  = 16;
  localparam int CW  = 16;
  localparam int AW  = 35;
  localparam int SOW = 16;
  localparam int LAT = N + 2;
  localparam int HMAX = 1024;
  localparam logic signed [CW-1:0] CF [N] = '{16'sh8000, 16'sd1200, -16'sd3, 16'sd517,
                                             16'sh7FFF, -16'sd900, 16'sd64, 16'sd5};

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  valid_i = 1'b0;
  logic signed [SW-1:0]  sample_i = '0;
  logic                  valid_full, valid_sat;
  logic signed [AW-1:0]  res_full;
  logic signed [SOW-1:0] res_sat;

  int     n_tests = 0;
  int     n_fail  = 0;
  int     e       = 0;
  longint xh [HMAX];
  bit     vh [HMAX];

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_systolic #(.N(N), .SW(SW), .CW(CW), .COEFS(CF)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sample_i(sample_i),
    .valid_o(valid_full), .result_o(res_full));

  fir_systolic #(.N(N), .SW(SW), .CW(CW), .COEFS(CF), .OW(SOW)) dut_sat_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sample_i(sample_i),
    .valid_o(valid_sat), .result_o(res_sat));

  task automatic check_at(input int ed, input string tag);
    int     idx;
    bit     ev;
    longint ey, es, af, as_;
    idx = ed - LAT;
    ev  = (idx >= 0) && vh[idx];
    ey  = 0;
    for (int k = 0; k < N; k++)
      if (idx - k >= 0) ey += longint'(CF[k]) * xh[idx-k];
    es  = (ey > 32767) ? 32767 : (ey < -32768) ? -32768 : ey;
    af  = longint'(res_full);
    as_ = longint'(res_sat);
    n_tests++;
    if (valid_full !== ev || af != ey || valid_sat !== ev || as_ != es) begin
      n_fail++;
      $display("FAIL %s edge %0d: valid %b/%b res %0d sat %0d, expected valid %b res %0d sat %0d",
               tag, ed, valid_full, valid_sat, af, as_, ev, ey, es);
    end
  endtask

  task automatic tick(input logic signed [SW-1:0] x, input bit v, input string tag);
    valid_i  = v;
    sample_i = x;
    xh[e] = v ? longint'(x) : 0;
    vh[e] = v;
    @(posedge clk);
    e++;
    @(negedge clk);
    check_at(e - 1, tag);
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < LAT + N; i++) tick('0, 1'b0, tag);
  endtask

  // R1: outputs held at zero during reset while inputs toggle
  task automatic t_reset();
    @(negedge clk);
    rst_ni   = 1'b0;
    valid_i  = 1'b1;
    sample_i = 16'sh7FFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      n_tests++;
      if (valid_full !== 1'b0 || res_full != '0 || valid_sat !== 1'b0 || res_sat != '0) begin
        n_fail++;
        $display("FAIL R1: valid %b res %0d during reset, expected 0 and 0", valid_full, res_full);
      end
    end
    valid_i  = 1'b0;
    sample_i = '0;
    rst_ni   = 1'b1;
    e        = 0;
  endtask

  // R9, R3, R6: unit impulse returns coefficients in order at fixed latency
  task automatic t_impulse();
    t_reset();
    tick(16'sd1, 1'b1, "R9");
    for (int i = 0; i < LAT + N + 2; i++) tick('0, 1'b1, "R3");
    flush("R6");
  endtask

  // R4, R2: step input, valid every cycle after fill
  task automatic t_step();
    t_reset();
    for (int i = 0; i < 40; i++) tick(16'sd1000, 1'b1, "R4");
    flush("R2");
  endtask

  // R2, R7: random signed stream
  task automatic t_random();
    t_reset();
    for (int i = 0; i < 300; i++) tick(16'($urandom), 1'b1, "R2");
    flush("R7");
  endtask

  // R8, R7: most negative sample, full-scale alternation
  task automatic t_extreme();
    t_reset();
    for (int i = 0; i < 30; i++) tick(16'sh8000, 1'b1, "R8");
    for (int i = 0; i < 30; i++) tick((i % 2) ? 16'sh8000 : 16'sh7FFF, 1'b1, "R8");
    for (int i = 0; i < 30; i++) tick(16'sh7FFF, 1'b1, "R7");
    flush("R8");
  endtask

  // R5, R6: gaps carry junk on sample_i that must be seen as zero
  task automatic t_gaps();
    t_reset();
    for (int i = 0; i < 80; i++) begin
      if (i % 3 == 1) tick(16'sh7FFF, 1'b0, "R5");
      else            tick(16'(i * 97 - 2000), 1'b1, "R5");
    end
    for (int i = 0; i < 20; i++) tick(16'sh8000, (i % 5 == 0), "R6");
    flush("R5");
  endtask

  initial begin
    t_impulse();
    t_step();
    t_random();
    t_extreme();
    t_gaps();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule